// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences a successive-approximation analog-to-digital conversion. It sends a trial code to an external DAC and reads back one comparator bit. A conversion starts with a programmable acquisition window, during which the sample switch is closed. The block then makes one bit decision per bit period, working from the most significant bit down to the least significant bit. The bit period is a selectable multiple of the system clock.

Software starts a conversion with a one-cycle `go` strobe and polls `busy`. `busy` drops by itself on the cycle the result is captured, and `done` pulses on that cycle. The 10-bit result is shown across two 8-bit result bytes, either right- or left-justified. An enable input gates the whole sequencer.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy`, `sample_closed` and `done` are 0, `trial_code` is 0, and both result bytes read 0.
- R2: A `go` strobe taken while `enable` is 1 and `busy` is 0 sets `busy` on the next clock. `sample_closed` is then 1 for exactly `acq_len` clocks, and an `acq_len` of 0 is treated as 1.
- R3: On the first clock after acquisition, `sample_closed` is 0 and `trial_code` is midscale (only bit 9 set, 0x200).
- R4: Each trial keeps its bit when `cmp_in` is 1 and clears it when `cmp_in` is 0, then sets the next lower bit. So when `cmp_in` is 1 exactly when the input is at or above `trial_code`, the result equals the input code.
- R5: Each bit period lasts 2, 8 or 32 clocks for `clk_sel` 0, 1 or 2. A `clk_sel` of 3 also gives 32 clocks. `busy` stays high for max(`acq_len`,1) + 10 × period clocks.
- R6: `busy` clears by itself on the clock the result is captured. `done` is 1 for exactly that one clock.
- R7: With `right_just` = 1, `res_hi` is {6'b0, result[9:8]} and `res_lo` is result[7:0].
- R8: With `right_just` = 0, `res_hi` is result[9:2] and `res_lo` is {result[1:0], 6'b0}. Justification follows `right_just` at all times.
- R9: A `go` strobe while `busy` is 1 is ignored. The running conversion's length and result are unchanged.
- R10: While `enable` is 0, `busy` and `sample_closed` are 0 and `go` is ignored. Dropping `enable` mid-conversion aborts it, with no `done` pulse and no change to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; 0 holds the sequencer idle |
| go | input | 1 | Start strobe |
| clk_sel | input | 2 | Bit-period select: 0→2, 1→8, 2/3→32 clocks |
| acq_len | input | ACQ_W | Acquisition length in clocks (0 acts as 1) |
| right_just | input | 1 | 1 = right-justified result bytes, 0 = left |
| cmp_in | input | 1 | Comparator: 1 when input ≥ trial code |
| trial_code | output | RES_W | Code driven to the DAC |
| sample_closed | output | 1 | Sample switch closed (acquisition) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-clock pulse when the result is captured |
| res_hi | output | 8 | Upper result byte |
| res_lo | output | 8 | Lower result byte |

## Verification
The bench builds the block with the default parameters: a 10-bit result and an 8-bit acquisition count. This makes every `clk_sel` code, including the spare code 3, and acquisition lengths of 0 and small values reachable within a short run. A behavioural comparator in the bench compares `trial_code` with a chosen input code. This turns every bit decision into a check on the final result, including the all-zero and all-one extremes. Strobes during a busy conversion, enable drops and aborts mid-conversion, and live justification changes are covered by directed cases.

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int RES_W = 10,
  parameter int ACQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             go,
  input  logic [1:0]       clk_sel,
  input  logic [ACQ_W-1:0] acq_len,
  input  logic             right_just,
  input  logic             cmp_in,
  output logic [RES_W-1:0] trial_code,
  output logic             sample_closed,
  output logic             busy,
  output logic             done,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);
  localparam int PACK_W = 16;
  localparam int PAD_W  = PACK_W - RES_W;
  localparam int DIV_W  = 5;
  localparam logic [RES_W-1:0] MID = RES_W'(1) << (RES_W - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_TRIAL} st_t;

  st_t              st;
  logic [ACQ_W-1:0] acq_cnt, acq_lim;
  logic [DIV_W-1:0] div_cnt, per_lim, per_sel;
  logic [RES_W-1:0] trial, cur_bit, decided, result;
  logic [PACK_W-1:0] packed_res;

  assign per_sel = (clk_sel == 2'd0) ? DIV_W'(1) : (clk_sel == 2'd1) ? DIV_W'(7) : DIV_W'(31);
  assign decided = cmp_in ? trial : (trial & ~cur_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      acq_cnt <= '0;
      acq_lim <= '0;
      div_cnt <= '0;
      per_lim <= '0;
      trial   <= '0;
      cur_bit <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else if (!enable) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (go) begin
          st      <= ST_ACQ;
          acq_cnt <= '0;
          acq_lim <= (acq_len == '0) ? ACQ_W'(1) : acq_len;
          per_lim <= per_sel;
        end
        ST_ACQ: begin
          if (acq_cnt == acq_lim - ACQ_W'(1)) begin
            st      <= ST_TRIAL;
            trial   <= MID;
            cur_bit <= MID;
            div_cnt <= '0;
          end else begin
            acq_cnt <= acq_cnt + ACQ_W'(1);
          end
        end
        ST_TRIAL: begin
          if (div_cnt == per_lim) begin
            div_cnt <= '0;
            if (cur_bit[0]) begin
              trial  <= decided;
              result <= decided;
              st     <= ST_IDLE;
              done   <= 1'b1;
            end else begin
              trial   <= decided | (cur_bit >> 1);
              cur_bit <= cur_bit >> 1;
            end
          end else begin
            div_cnt <= div_cnt + DIV_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy          = enable && (st != ST_IDLE);
  assign sample_closed = enable && (st == ST_ACQ);
  assign trial_code    = trial;
  assign packed_res    = right_just ? {{PAD_W{1'b0}}, result} : {result, {PAD_W{1'b0}}};
  assign res_hi        = packed_res[PACK_W-1:8];
  assign res_lo        = packed_res[7:0];
endmodule

module sar_conv_ctrl_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             go,
  input logic             right_just,
  input logic [RES_W-1:0] trial_code,
  input logic             sample_closed,
  input logic             busy,
  input logic             done,
  input logic [7:0]       res_hi,
  input logic [7:0]       res_lo
);
  // R2
  acq_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) sample_closed |-> busy);
  // R3
  mid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_closed) && busy) |-> (trial_code == (RES_W'(1) << (RES_W - 1))));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy)));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  right_pad_chk: assert property (@(posedge clk) disable iff (!rst_n) right_just |-> (res_hi[7:2] == 6'd0));
  // R8
  left_pad_chk: assert property (@(posedge clk) disable iff (!rst_n) !right_just |-> (res_lo[5:0] == 6'd0));
  // R9
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && enable) |=> (busy || done || !enable));
  // R10
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !enable |-> (!busy && !sample_closed));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .go(go), .right_just(right_just),
  .trial_code(trial_code), .sample_closed(sample_closed), .busy(busy), .done(done),
  .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       go = 1'b0;
  logic [1:0] clk_sel = 2'd0;
  logic [7:0] acq_len = 8'd0;
  logic       right_just = 1'b1;
  logic [9:0] vin = 10'd0;
  logic       cmp_in;
  logic [9:0] trial_code;
  logic       sample_closed, busy, done;
  logic [7:0] res_hi, res_lo;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [9:0] last_res = 10'd0;

  always #5 clk = ~clk;
  assign cmp_in = (vin >= trial_code);

  sar_conv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .go(go), .clk_sel(clk_sel),
    .acq_len(acq_len), .right_just(right_just), .cmp_in(cmp_in),
    .trial_code(trial_code), .sample_closed(sample_closed), .busy(busy),
    .done(done), .res_hi(res_hi), .res_lo(res_lo)
  );

  function automatic int period_of(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 8 : 32;
  endfunction

  function automatic logic [15:0] fmt(input logic [9:0] r, input logic rj);
    return rj ? {6'd0, r} : {r, 6'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input logic [9:0] r);
    logic [15:0] e;
    e = fmt(r, right_just);
    chk({res_hi, res_lo} == e, req, {res_hi, res_lo}, e);
  endtask

  task automatic run_conv(input logic [9:0] v, input logic [1:0] sel, input logic [7:0] acq,
                          input bit rj, input bit poke);
    int nb, ns, exp_acq, exp_b;
    bit seen;
    vin = v; clk_sel = sel; acq_len = acq; right_just = rj;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    chk(busy == 1'b1, "R2 busy after go", busy, 1);
    exp_acq = (acq == 8'd0) ? 1 : int'(acq);
    exp_b = exp_acq + 10 * period_of(sel);
    nb = 0; ns = 0; seen = 0;
    while (busy && nb < 2000) begin
      nb++;
      if (sample_closed) ns++;
      else if (!seen) begin
        seen = 1;
        chk(trial_code == 10'h200, "R3 first trial midscale", trial_code, 10'h200);
      end
      go = (poke && (nb == 5 || nb == exp_acq + 3));
      @(negedge clk);
    end
    go = 1'b0;
    chk(ns == exp_acq, "R2 acquisition length", ns, exp_acq);
    chk(nb == exp_b, poke ? "R9 busy length with go while busy" : "R5 busy length", nb, exp_b);
    chk(done == 1'b1, "R6 done pulse at completion", done, 1);
    chk_res(poke ? "R9 result unaffected" : (rj ? "R4 R7 result right" : "R4 R8 result left"), v);
    last_res = v;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R6 done one clock", {done, busy}, 0);
  endtask

  initial begin
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    chk(busy == 0 && sample_closed == 0 && done == 0, "R1 reset status", {busy, sample_closed, done}, 0);
    chk(trial_code == 0, "R1 reset trial", trial_code, 0);
    chk(res_hi == 0 && res_lo == 0, "R1 reset result", {res_hi, res_lo}, 0);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);

    run_conv(10'h000, 2'd0, 8'd0, 1'b1, 1'b0);
    run_conv(10'h3FF, 2'd1, 8'd1, 1'b0, 1'b0);
    run_conv(10'h200, 2'd2, 8'd4, 1'b1, 1'b0);
    run_conv(10'h1FF, 2'd3, 8'd2, 1'b0, 1'b0);
    run_conv(10'h2A5, 2'd1, 8'd6, 1'b1, 1'b1);

    right_just = 1'b0; @(negedge clk); chk_res("R8 live left justify", last_res);
    right_just = 1'b1; @(negedge clk); chk_res("R7 live right justify", last_res);

    for (int i = 0; i < 24; i++)
      run_conv(10'($urandom), 2'($urandom), 8'($urandom % 21), 1'($urandom), 1'b0);

    enable = 1'b0;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(busy == 0 && sample_closed == 0, "R10 go ignored while disabled", {busy, sample_closed}, 0);
      @(negedge clk);
    end
    chk_res("R10 result kept while disabled", last_res);

    enable = 1'b1; vin = 10'h155; clk_sel = 2'd1; acq_len = 8'd3;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy == 1'b1, "R10 running before abort", busy, 1);
    enable = 1'b0;
    #1 chk(busy == 0 && sample_closed == 0, "R10 abort idles", {busy, sample_closed}, 0);
    for (int k = 0; k < 90; k++) begin
      @(negedge clk);
      if (done) chk(0, "R10 no done after abort", done, 0);
    end
    chk_res("R10 result unchanged by abort", last_res);
    enable = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 stays idle after re-enable", busy, 0);
    run_conv(10'h155, 2'd0, 8'd0, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule